// File: doc/BRIEF.md
# Level-Interrupt Acknowledge Broadcast with Storm Throttle

This block sits beside an interrupt redirection table and handles end-of-interrupt notifications. When a vector is acknowledged, every pin whose table entry carries that vector, is programmed for level triggering and has its in-service (remote-pending) flag set is acknowledged in a single clock: the block emits a clear pulse for each such flag. For an acknowledged pin that is unmasked and whose request is still held high, the block asks for immediate redelivery on that pin.

A pin whose line stays asserted through acknowledge after acknowledge can flood the system. Each pin therefore has a counter of back-to-back redeliveries. When the counter would reach a fixed limit, it restarts from zero. The redelivery is then not issued at once. Instead, a single shared timer is armed, and a global service pulse is issued after a fixed number of time-base ticks. The time base is an external enable strobe, so the delay is set in ticks and does not depend on the core clock. A write to a pin's table entry restarts that pin's counter.

Top module: `eoi_storm_throttle`

## Requirements
- R1: A pin is acknowledged by an end-of-interrupt only when `eoi_valid_i` is high, its entry vector equals `eoi_vector_i`, its trigger bit is 1 (level), and its remote-pending flag is 1. A pin that fails any of these tests gets no clear, no request, and no change to its counter.
- R2: In the clock after the notification, `remote_clr_o` has bit n high for every acknowledged pin n, all of them together, for one cycle.
- R3: For an acknowledged pin that is unmasked (mask bit 0) and whose request bit is 1, the redelivery counter increments. For any other acknowledged pin, the counter returns to zero.
- R4: When the incremented count stays below `STORM_LIMIT`, `svc_req_o[n]` pulses high for one cycle, in the clock after the notification.
- R5: When the incremented count would reach `STORM_LIMIT`, the counter returns to zero, no immediate request is issued, and a deferred service is requested.
- R6: A deferred service that is started while none is pending makes `svc_defer_o` pulse for one cycle. The pulse comes in the clock after the `DEFER_TICKS`-th clock edge with `tick_i` high that follows the starting edge.
- R7: A deferral request that arrives while one is already pending is dropped, and the earlier expiry is kept.
- R8: A high `entry_wr_i[n]` resets pin n's counter. In the same clock it overrides any increment, request or deferral for that pin, but the remote-flag clear still happens.
- R9: After reset, all outputs are low, all counters are zero, and no deferral is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| eoi_valid_i | input | 1 | End-of-interrupt strobe |
| eoi_vector_i | input | VEC_W | Acknowledged vector |
| pin_vec_i | input | NUM_PINS*VEC_W | Entry vector of each pin, pin n at bits [n*VEC_W +: VEC_W] |
| pin_level_i | input | NUM_PINS | Trigger mode per pin, 1 = level |
| pin_mask_i | input | NUM_PINS | Mask per pin, 1 = masked |
| pin_remote_i | input | NUM_PINS | Remote-pending flag per pin |
| pin_irr_i | input | NUM_PINS | Request still asserted per pin |
| entry_wr_i | input | NUM_PINS | Table entry write strobe per pin |
| tick_i | input | 1 | Time-base enable for the deferral delay |
| remote_clr_o | output | NUM_PINS | Clear pulse for each acknowledged remote flag |
| svc_req_o | output | NUM_PINS | Immediate redelivery request per pin |
| svc_defer_o | output | 1 | Deferred global service pulse |

## Verification
Any pin's redelivery counter can drift from its true value without showing at once. The error appears only at the acknowledgement where that pin reaches the limit: either an immediate request where the pin should have deferred, or a deferral where it should have asked at once. The bench therefore drives runs of acknowledges after masking, after a deasserted request and after entry writes, so that a wrong count shows within a few notifications. A timer that is wrongly re-armed or mis-counted moves the single `svc_defer_o` pulse, or adds a second one, within `DEFER_TICKS` ticks. An error in the match logic shows one clock after the notification, as wrong bits in `remote_clr_o`.

// File: rtl/eoi_pkg.sv
package eoi_pkg;

  function automatic logic eoi_hit(
    input logic       valid,
    input logic [7:0] eoi_vec,
    input logic [7:0] pin_vec,
    input logic       level,
    input logic       remote
  );
    return valid && (eoi_vec == pin_vec) && level && remote;
  endfunction

endpackage

// File: rtl/eoi_match.sv
module eoi_match #(
  parameter int NUM_PINS = 24,
  parameter int VEC_W    = 8
) (
  input  logic                      eoi_valid_i,
  input  logic [VEC_W-1:0]          eoi_vector_i,
  input  logic [NUM_PINS*VEC_W-1:0] pin_vec_i,
  input  logic [NUM_PINS-1:0]       pin_level_i,
  input  logic [NUM_PINS-1:0]       pin_mask_i,
  input  logic [NUM_PINS-1:0]       pin_remote_i,
  input  logic [NUM_PINS-1:0]       pin_irr_i,
  output logic [NUM_PINS-1:0]       hit_o,
  output logic [NUM_PINS-1:0]       redeliver_o
);
  import eoi_pkg::*;

  for (genvar n = 0; n < NUM_PINS; n++) begin : g_pin
    logic [7:0] pv, ev;
    assign pv = 8'(pin_vec_i[n*VEC_W +: VEC_W]);
    assign ev = 8'(eoi_vector_i);
    assign hit_o[n]       = eoi_hit(eoi_valid_i, ev, pv, pin_level_i[n], pin_remote_i[n]);
    assign redeliver_o[n] = hit_o[n] && !pin_mask_i[n] && pin_irr_i[n];
  end

endmodule

// File: rtl/eoi_storm_counter.sv
module eoi_storm_counter #(
  parameter int STORM_LIMIT = 10000,
  localparam int CW = $clog2(STORM_LIMIT + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hit_i,
  input  logic redeliver_i,
  input  logic wr_i,
  output logic now_o,
  output logic defer_o
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW:0]   inc;

  assign inc = {1'b0, cnt_q} + (CW+1)'(1);

  always_comb begin
    cnt_d   = cnt_q;
    now_o   = 1'b0;
    defer_o = 1'b0;
    if (wr_i) begin
      cnt_d = '0;
    end else if (hit_i) begin
      if (redeliver_i) begin
        if (inc >= (CW+1)'(STORM_LIMIT)) begin
          cnt_d   = '0;
          defer_o = 1'b1;
        end else begin
          cnt_d = inc[CW-1:0];
          now_o = 1'b1;
        end
      end else begin
        cnt_d = '0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assert_cnt_below_limit_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < CW'(STORM_LIMIT));

  assert_wr_resets_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> cnt_q == '0);

  assert_miss_holds_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hit_i && !wr_i) |=> $stable(cnt_q));

endmodule

// File: rtl/eoi_defer_timer.sv
module eoi_defer_timer #(
  parameter int DEFER_TICKS = 10000,
  localparam int TW = $clog2(DEFER_TICKS + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic tick_i,
  output logic fire_o
);
  logic          pend_q, fire_q;
  logic [TW-1:0] rem_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      rem_q  <= '0;
      fire_q <= 1'b0;
    end else begin
      fire_q <= 1'b0;
      if (!pend_q) begin
        if (start_i) begin
          pend_q <= 1'b1;
          rem_q  <= TW'(DEFER_TICKS);
        end
      end else if (tick_i) begin
        if (rem_q == TW'(1)) begin
          pend_q <= 1'b0;
          rem_q  <= '0;
          fire_q <= 1'b1;
        end else begin
          rem_q <= rem_q - TW'(1);
        end
      end
    end
  end

  assign fire_o = fire_q;

  assert_remain_range_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q |-> (rem_q != '0 && rem_q <= TW'(DEFER_TICKS)));

  // earlier expiry kept: an armed timer is never reloaded upward
  assert_no_rearm_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && start_i && !tick_i) |=> (pend_q && $stable(rem_q)));

  assert_fire_single_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_q |=> !fire_q);

endmodule

// File: rtl/eoi_storm_throttle.sv
module eoi_storm_throttle #(
  parameter int NUM_PINS    = 24,
  parameter int VEC_W       = 8,
  parameter int STORM_LIMIT = 10000,
  parameter int DEFER_TICKS = 10000
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      eoi_valid_i,
  input  logic [VEC_W-1:0]          eoi_vector_i,
  input  logic [NUM_PINS*VEC_W-1:0] pin_vec_i,
  input  logic [NUM_PINS-1:0]       pin_level_i,
  input  logic [NUM_PINS-1:0]       pin_mask_i,
  input  logic [NUM_PINS-1:0]       pin_remote_i,
  input  logic [NUM_PINS-1:0]       pin_irr_i,
  input  logic [NUM_PINS-1:0]       entry_wr_i,
  input  logic                      tick_i,
  output logic [NUM_PINS-1:0]       remote_clr_o,
  output logic [NUM_PINS-1:0]       svc_req_o,
  output logic                      svc_defer_o
);
  logic [NUM_PINS-1:0] hit, redeliver, now_req, defer_req;
  logic [NUM_PINS-1:0] clr_q, req_q;

  eoi_match #(.NUM_PINS(NUM_PINS), .VEC_W(VEC_W)) u_match (
    .eoi_valid_i (eoi_valid_i),
    .eoi_vector_i(eoi_vector_i),
    .pin_vec_i   (pin_vec_i),
    .pin_level_i (pin_level_i),
    .pin_mask_i  (pin_mask_i),
    .pin_remote_i(pin_remote_i),
    .pin_irr_i   (pin_irr_i),
    .hit_o       (hit),
    .redeliver_o (redeliver)
  );

  for (genvar n = 0; n < NUM_PINS; n++) begin : g_cnt
    eoi_storm_counter #(.STORM_LIMIT(STORM_LIMIT)) u_cnt (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .hit_i      (hit[n]),
      .redeliver_i(redeliver[n]),
      .wr_i       (entry_wr_i[n]),
      .now_o      (now_req[n]),
      .defer_o    (defer_req[n])
    );
  end

  eoi_defer_timer #(.DEFER_TICKS(DEFER_TICKS)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(|defer_req),
    .tick_i (tick_i),
    .fire_o (svc_defer_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      clr_q <= '0;
      req_q <= '0;
    end else begin
      clr_q <= hit;
      req_q <= now_req;
    end
  end

  assign remote_clr_o = clr_q;
  assign svc_req_o    = req_q;

  assert_clr_needs_eoi_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|remote_clr_o) |-> $past(eoi_valid_i));

  assert_req_within_clr_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (svc_req_o & ~remote_clr_o) == '0);

  assert_req_excl_defer_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (now_req & defer_req) == '0);

endmodule

// File: tb/eoi_storm_throttle_bench.sv
`timescale 1ns/1ps
module eoi_storm_throttle_bench;
  localparam int NP = 4;
  localparam int VW = 8;
  localparam int LIM = 4;
  localparam int DT = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic eoi_valid = 1'b0;
  logic [VW-1:0] eoi_vector = '0;
  logic [NP*VW-1:0] pin_vec;
  logic [NP-1:0] pin_level, pin_mask, pin_remote, pin_irr, entry_wr;
  logic tick = 1'b0;
  logic [NP-1:0] remote_clr, svc_req;
  logic svc_defer;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  eoi_storm_throttle #(.NUM_PINS(NP), .VEC_W(VW), .STORM_LIMIT(LIM), .DEFER_TICKS(DT)) u_eoi_storm_throttle (
    .clk_i(clk), .rst_ni(rst_n), .eoi_valid_i(eoi_valid), .eoi_vector_i(eoi_vector),
    .pin_vec_i(pin_vec), .pin_level_i(pin_level), .pin_mask_i(pin_mask),
    .pin_remote_i(pin_remote), .pin_irr_i(pin_irr), .entry_wr_i(entry_wr),
    .tick_i(tick), .remote_clr_o(remote_clr), .svc_req_o(svc_req), .svc_defer_o(svc_defer)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int mcnt[NP];
  bit mpend;
  int mrem;
  logic [NP-1:0] e_clr, e_req;
  logic e_def;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (mcnt[i]) mcnt[i] = 0;
      mpend = 0; mrem = 0; e_clr = '0; e_req = '0; e_def = 0;
    end else begin
      bit anydef;
      anydef = 0;
      e_clr = '0; e_req = '0; e_def = 0;
      for (int i = 0; i < NP; i++) begin
        bit aff, red;
        aff = eoi_valid && pin_vec[i*VW +: VW] == eoi_vector && pin_level[i] && pin_remote[i];
        red = aff && !pin_mask[i] && pin_irr[i];
        e_clr[i] = aff;
        if (entry_wr[i]) mcnt[i] = 0;
        else if (aff) begin
          if (red) begin
            if (mcnt[i] + 1 >= LIM) begin mcnt[i] = 0; anydef = 1; end
            else begin mcnt[i]++; e_req[i] = 1; end
          end else mcnt[i] = 0;
        end
      end
      if (mpend) begin
        if (tick) begin
          if (mrem == 1) begin mpend = 0; e_def = 1; end
          else mrem--;
        end
      end else if (anydef) begin
        mpend = 1; mrem = DT;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R2 clear vs model", 32'(remote_clr), 32'(e_clr));
      chk("R4 R5 request vs model", 32'(svc_req), 32'(e_req));
      chk("R6 R7 deferral vs model", 32'(svc_defer), 32'(e_def));
    end
  end

  always @(negedge clk) tick <= ~tick;

  task automatic eoi(input logic [7:0] v, input string req,
                     input logic [NP-1:0] x_clr, input logic [NP-1:0] x_req);
    @(negedge clk);
    eoi_valid = 1'b1; eoi_vector = v;
    @(negedge clk);
    eoi_valid = 1'b0; entry_wr = '0;
    chk({req, " clr"}, 32'(remote_clr), 32'(x_clr));
    chk({req, " req"}, 32'(svc_req), 32'(x_req));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int pulses;
    pin_vec    = {8'h30, 8'h41, 8'h30, 8'h30};
    pin_level  = 4'b0111;
    pin_mask   = '0;
    pin_remote = '1;
    pin_irr    = '1;
    entry_wr   = '0;
    repeat (3) @(negedge clk);
    chk("R9 reset clr", 32'(remote_clr), 0);
    chk("R9 reset req", 32'(svc_req), 0);
    chk("R9 reset defer", 32'(svc_defer), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 idle after reset", 32'({remote_clr, svc_req, svc_defer}), 0);

    // R1: pin3 edge, pin2 other vector; pins 0,1 acknowledged together
    eoi(8'h30, "R1 R2 shared vector", 4'b0011, 4'b0011);
    eoi(8'h55, "R1 no match", 4'b0000, 4'b0000);
    pin_remote[1] = 1'b0;
    eoi(8'h30, "R1 remote low", 4'b0001, 4'b0001);        // p0 cnt 2
    pin_mask[0] = 1'b1;
    eoi(8'h30, "R3 masked", 4'b0001, 4'b0000);            // p0 cnt 0
    pin_mask[0] = 1'b0;
    eoi(8'h30, "R3 after reset 1", 4'b0001, 4'b0001);
    eoi(8'h30, "R3 after reset 2", 4'b0001, 4'b0001);
    eoi(8'h30, "R4 below limit", 4'b0001, 4'b0001);
    eoi(8'h30, "R5 limit defers", 4'b0001, 4'b0000);      // timer armed
    // second deferral from pin2 while pending
    eoi(8'h41, "R4 p2 1", 4'b0100, 4'b0100);
    eoi(8'h41, "R4 p2 2", 4'b0100, 4'b0100);
    eoi(8'h41, "R4 p2 3", 4'b0100, 4'b0100);
    eoi(8'h41, "R7 defer while pending", 4'b0100, 4'b0000);
    pulses = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (svc_defer) pulses++;
    end
    chk("R6 R7 one deferred pulse", 32'(pulses), 1);

    // R8: write resets count
    eoi(8'h41, "R8 pre 1", 4'b0100, 4'b0100);
    eoi(8'h41, "R8 pre 2", 4'b0100, 4'b0100);
    eoi(8'h41, "R8 pre 3", 4'b0100, 4'b0100);
    @(negedge clk); entry_wr = 4'b0100;
    @(negedge clk); entry_wr = '0;
    eoi(8'h41, "R8 after write", 4'b0100, 4'b0100);
    entry_wr = 4'b0100;
    eoi(8'h41, "R8 write same cycle", 4'b0100, 4'b0000);
    eoi(8'h41, "R8 restart", 4'b0100, 4'b0100);

    // R3: request deasserted resets
    pin_remote[1] = 1'b1;
    pin_irr[0] = 1'b0;
    eoi(8'h30, "R3 irr low", 4'b0011, 4'b0010);
    pin_irr[0] = 1'b1;

    pulses = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (svc_defer) pulses++;
    end
    chk("R6 no spurious deferral", 32'(pulses), 0);

    done = 1;
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule